// File: doc/BRIEF.md
# Multi-format stereo PCM serial receiver

This block takes a three-wire stereo audio link (bit clock, frame clock, data line) and turns it into a pair of 24-bit parallel sample words, one for each channel, plus a one-cycle strobe per frame. The three link wires are synchronous with the system clock and slower than it; the block samples them on the system clock and acts on each detected rising edge of the bit clock.

A 3-bit format input selects, at run time, one of five framings: three LSB-justified widths (16, 20 and 24 bits), 24-bit MSB-justified, and I2S. Shorter samples are placed at the top of the 24-bit word so that full scale matches the 24-bit formats. A small state machine follows the channel order: `ST_HUNT` after reset waits for a left word to begin (HUNT to LEFT on a word boundary into the left channel), `ST_LEFT` collects the left word and moves to `ST_RIGHT` at the next boundary (LEFT to RIGHT, left word held), and `ST_RIGHT` collects the right word and returns to `ST_LEFT` at the next boundary (RIGHT to LEFT, both words presented with the strobe).

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset `word_valid` is 0 and both output words are 0.
- R2: A data bit is taken at each rising edge of `bclk`; words are sent most significant bit first in two's complement.
- R3: `fmt_sel` codes: 0 = 16-bit LSB-justified, 1 = 20-bit LSB-justified, 2 = 24-bit MSB-justified, 3 = I2S, 4 = 24-bit LSB-justified; codes 5 to 7 behave as code 3.
- R4: In LSB-justified formats the last bit of each half frame is the sample's least significant bit, taken at the last `bclk` rise before the frame clock changes level; all earlier bits of that half beyond the sample width have no effect.
- R5: 16-bit and 20-bit samples appear in bits 23 down to 8 (or 4) of the output word, with the low 8 (or 4) bits zero.
- R6: In MSB-justified format the first bit after a frame clock change is bit 23; bits after the 24th in a half frame have no effect.
- R7: In I2S format the left channel is sent while `fclk` is low, and a word's bit 23 comes one `bclk` rise after the frame clock change.
- R8: In the formats other than I2S the left channel is sent while `fclk` is high, with no bit delay.
- R9: Once per frame, after the right word completes, `word_valid` is 1 for exactly one cycle with both words of that frame on the outputs.
- R10: A half frame with too few bits still produces a word: in MSB-justified and I2S formats the missing low bits read as 0, in LSB-justified formats the missing high bits read as 0.
- R11: After reset no strobe is given until a complete left word followed by a complete right word has arrived.
- R12: The output words change only in the cycle in which `word_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Frame (channel select) clock |
| sdata | input | 1 | Serial data line |
| fmt_sel | input | 3 | Framing format code |
| left_word | output | 24 | Left channel sample |
| right_word | output | 24 | Right channel sample |
| word_valid | output | 1 | One-cycle strobe, both words new |

## Verification
Assertions watch on every cycle that the strobe never lasts more than one cycle, that it is only raised when the machine has just closed a right word, that no strobe follows a hunting cycle, that the output words are held between strobes, and that outside I2S a new left word starts only with the frame clock high. Whether the right bits land in the right places for each format, with don't-care bits driven at random, the one-bit I2S delay, the left alignment of short samples, the handling of short half frames and the mapping of the unused format codes can only be shown by the bench scenarios comparing captured words against values worked out from the requirements.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_e;

    localparam logic [2:0] FMT_LSB16 = 3'd0;
    localparam logic [2:0] FMT_LSB20 = 3'd1;
    localparam logic [2:0] FMT_MSB24 = 3'd2;
    localparam logic [2:0] FMT_I2S   = 3'd3;
    localparam logic [2:0] FMT_LSB24 = 3'd4;

    typedef enum logic [1:0] {
        WSEL_SHORT = 2'd0,
        WSEL_MID   = 2'd1,
        WSEL_FULL  = 2'd2
    } width_sel_e;

    typedef struct packed {
        logic       i2s;
        logic       lsb;
        width_sel_e wsel;
    } fmt_dec_t;

    function automatic fmt_dec_t decode_fmt(input logic [2:0] code);
        fmt_dec_t d;
        d = '{i2s: 1'b1, lsb: 1'b0, wsel: WSEL_FULL};
        case (code)
            FMT_LSB16: d = '{i2s: 1'b0, lsb: 1'b1, wsel: WSEL_SHORT};
            FMT_LSB20: d = '{i2s: 1'b0, lsb: 1'b1, wsel: WSEL_MID};
            FMT_MSB24: d = '{i2s: 1'b0, lsb: 1'b0, wsel: WSEL_FULL};
            FMT_LSB24: d = '{i2s: 1'b0, lsb: 1'b1, wsel: WSEL_FULL};
            default:   d = '{i2s: 1'b1, lsb: 1'b0, wsel: WSEL_FULL};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcm_rx_sampler.sv
module pcm_rx_sampler #(
    parameter int PINS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins,
    output logic [PINS-1:0] pins_q,
    output logic            bclk_rise
);

    logic bclk_d;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins_q[g] <= 1'b0;
            else        pins_q[g] <= pins[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= pins_q[0];
    end

    assign bclk_rise = pins_q[0] & ~bclk_d;

endmodule

// File: rtl/pcm_rx_word.sv
module pcm_rx_word
    import pcm_rx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int W_SHORT = 16,
    parameter int W_MID   = 20,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              ws,
    input  logic              sd,
    input  fmt_dec_t          dec,
    output logic              boundary,
    output logic              left_now,
    output logic [DATA_W-1:0] word_done
);

    localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};
    localparam int SH_SHORT = DATA_W - W_SHORT;
    localparam int SH_MID   = DATA_W - W_MID;

    logic              ws_prev;
    logic              chan_prev;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] lsb_sh;
    logic [DATA_W-1:0] msb_sh;
    logic [DATA_W-1:0] lsb_word;

    // I2S lags the channel flag by one bit: use the frame clock seen one rise earlier.
    assign left_now = dec.i2s ? ~ws_prev : ws;
    assign boundary = rise && (left_now != chan_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev   <= 1'b0;
            chan_prev <= 1'b0;
            cnt       <= '0;
            lsb_sh    <= '0;
            msb_sh    <= '0;
        end else if (rise) begin
            ws_prev   <= ws;
            chan_prev <= left_now;
            if (boundary) begin
                cnt    <= CNT_W'(1);
                lsb_sh <= {{(DATA_W-1){1'b0}}, sd};
                msb_sh <= sd ? TOP_ONE : '0;
            end else begin
                if (cnt != '1) cnt <= cnt + 1'b1;
                lsb_sh <= {lsb_sh[DATA_W-2:0], sd};
                // a shift of DATA_W or more clears the mask, so extra bits drop out
                msb_sh <= msb_sh | (sd ? (TOP_ONE >> cnt) : '0);
            end
        end
    end

    always_comb begin
        unique case (dec.wsel)
            WSEL_SHORT: lsb_word = lsb_sh << SH_SHORT;
            WSEL_MID:   lsb_word = lsb_sh << SH_MID;
            default:    lsb_word = lsb_sh;
        endcase
        word_done = dec.lsb ? lsb_word : msb_sh;
    end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int W_SHORT = 16,
    parameter int W_MID   = 20,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fclk,
    input  logic              sdata,
    input  logic [2:0]        fmt_sel,
    output logic [DATA_W-1:0] left_word,
    output logic [DATA_W-1:0] right_word,
    output logic              word_valid
);

    localparam int PINS = 3;

    logic [PINS-1:0]   pins_q;
    logic              rise;
    logic              boundary;
    logic              left_now;
    logic [DATA_W-1:0] word_done;
    logic [DATA_W-1:0] left_hold;
    fmt_dec_t          dec;
    rx_state_e         state, nxt;

    assign dec = decode_fmt(fmt_sel);

    pcm_rx_sampler #(.PINS(PINS)) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      ({sdata, fclk, bclk}),
        .pins_q    (pins_q),
        .bclk_rise (rise)
    );

    pcm_rx_word #(
        .DATA_W  (DATA_W),
        .W_SHORT (W_SHORT),
        .W_MID   (W_MID),
        .CNT_W   (CNT_W)
    ) i_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .ws        (pins_q[1]),
        .sd        (pins_q[2]),
        .dec       (dec),
        .boundary  (boundary),
        .left_now  (left_now),
        .word_done (word_done)
    );

    always_comb begin
        nxt = state;
        if (boundary) begin
            unique case (state)
                ST_HUNT:  if (left_now) nxt = ST_LEFT;
                ST_LEFT:  nxt = ST_RIGHT;
                ST_RIGHT: nxt = ST_LEFT;
                default:  nxt = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold  <= '0;
            left_word  <= '0;
            right_word <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (boundary && state == ST_LEFT) left_hold <= word_done;
            if (boundary && state == ST_RIGHT) begin
                left_word  <= left_hold;
                right_word <= word_done;
                word_valid <= 1'b1;
            end
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r9_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (state == ST_LEFT));

    a_r11_no_strobe_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> !word_valid);

    a_r12_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(left_word) && $stable(right_word)));

    a_r8_left_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RIGHT && nxt == ST_LEFT && !dec.i2s) |-> pins_q[1]);

endmodule

// File: tb/test_pcm_serial_rx.sv
module test_pcm_serial_rx;

    localparam int CLK_PERIOD = 10;
    localparam int MAXF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt_sel = 3'd3;
    logic [23:0] left_word, right_word;
    logic        word_valid;

    int checks = 0;
    int bad = 0;
    int got_n = 0;
    logic [23:0] got_l [MAXF];
    logic [23:0] got_r [MAXF];
    logic [23:0] src_l [MAXF];
    logic [23:0] src_r [MAXF];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_serial_rx i_pcm_serial_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fclk       (fclk),
        .sdata      (sdata),
        .fmt_sel    (fmt_sel),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid)
    );

    always @(negedge clk) begin
        if (word_valid && got_n < MAXF) begin
            got_l[got_n] = left_word;
            got_r[got_n] = right_word;
        end
        if (word_valid) got_n = got_n + 1;
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lsb_width(input logic [2:0] f);
        return (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : (f == 3'd4) ? 24 : 0;
    endfunction

    function automatic bit is_i2s(input logic [2:0] f);
        return (f == 3'd3) || (f > 3'd4);
    endfunction

    // expected output word from the requirements (R4, R5, R6, R10)
    function automatic logic [23:0] expw(input logic [2:0] f, input logic [23:0] v, input int h);
        int n, av;
        logic [23:0] m;
        n = lsb_width(f);
        if (n != 0) begin
            av = (h < n) ? h : n;
            m = (av >= 24) ? 24'hFFFFFF : ((24'd1 << av) - 24'd1);
            return (v & m) << (24 - n);
        end
        av = (h < 24) ? h : 24;
        return v & ~(24'hFFFFFF >> av);
    endfunction

    function automatic logic dbit(input logic [2:0] f, input logic [23:0] v, input int h, input int j);
        int n, idx;
        n = lsb_width(f);
        if (n != 0) begin
            idx = h - 1 - j;
            return (idx < n) ? v[idx] : logic'($urandom & 1);
        end
        return (j < 24) ? v[23 - j] : logic'($urandom & 1);
    endfunction

    task automatic bit_out(input logic w, input logic d);
        @(negedge clk);
        bclk = 1'b0; fclk = w; sdata = d;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] f, input logic [23:0] lv, input logic [23:0] rv,
                              input int bpf, input int nbits);
        int h;
        h = bpf / 2;
        for (int t = 0; t < nbits; t++) begin
            logic w, d;
            d = (t < h) ? dbit(f, lv, h, t) : dbit(f, rv, h, t - h);
            if (is_i2s(f)) w = ((t + 1 < h) || (t + 1 == bpf)) ? 1'b0 : 1'b1;
            else           w = (t < h);
            bit_out(w, d);
        end
    endtask

    task automatic do_reset(input logic [2:0] f);
        @(negedge clk);
        rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0; fmt_sel = f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        got_n = 0;
        @(negedge clk);
    endtask

    task automatic run_frames(input logic [2:0] f, input int bpf, input int nf, input string req);
        do_reset(f);
        for (int k = 0; k < nf; k++) begin
            src_l[k] = 24'($urandom);
            src_r[k] = 24'($urandom);
            send_frame(f, src_l[k], src_r[k], bpf, bpf);
        end
        send_frame(f, 24'h0, 24'h0, bpf, 2);
        repeat (6) @(negedge clk);
        check({req, " R9 R11 frame count"}, 24'(got_n), 24'(nf));
        for (int k = 0; k < nf && k < got_n; k++) begin
            check({req, " left"},  got_l[k], expw(f, src_l[k], bpf / 2));
            check({req, " right"}, got_r[k], expw(f, src_r[k], bpf / 2));
        end
    endtask

    task automatic t_reset;
        do_reset(3'd3);
        check("R1 valid", {23'h0, word_valid}, 24'h0);
        check("R1 left", left_word, 24'h0);
        check("R1 right", right_word, 24'h0);
    endtask

    task automatic t_msb_nominal;   run_frames(3'd2, 64, 4, "R2 R6 R8 msb64");   endtask
    task automatic t_msb_minimum;   run_frames(3'd2, 48, 3, "R6 msb48");         endtask
    task automatic t_i2s_nominal;   run_frames(3'd3, 64, 4, "R7 i2s64");         endtask
    task automatic t_i2s_alias;     run_frames(3'd6, 64, 2, "R3 code6");         endtask
    task automatic t_lsb16;         run_frames(3'd0, 32, 3, "R3 R5 lsb16");      endtask
    task automatic t_lsb20;         run_frames(3'd1, 64, 3, "R4 R5 lsb20");      endtask
    task automatic t_lsb24;         run_frames(3'd4, 64, 3, "R4 R8 lsb24");      endtask
    task automatic t_short_msb;     run_frames(3'd2, 32, 2, "R10 msb short");    endtask
    task automatic t_short_i2s;     run_frames(3'd3, 40, 2, "R10 i2s short");    endtask
    task automatic t_short_lsb;     run_frames(3'd4, 32, 2, "R10 lsb short");    endtask

    task automatic t_hold;
        logic [23:0] l0, r0;
        run_frames(3'd2, 64, 1, "R12 base");
        l0 = left_word; r0 = right_word;
        send_frame(3'd2, 24'h123456, 24'h654321, 64, 40);
        check("R12 left held", left_word, l0);
        check("R12 right held", right_word, r0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_msb_nominal();
        t_msb_minimum();
        t_i2s_nominal();
        t_i2s_alias();
        t_lsb16();
        t_lsb20();
        t_lsb24();
        t_short_msb();
        t_short_i2s();
        t_short_lsb();
        t_hold();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule